// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine. Software writes 32-bit command words into a write-only queue and the engine carries out two drawing operations on a pixel framebuffer. The first is a solid rectangle fill. The second is a rectangle copy that stays correct when the source and destination rectangles overlap. Beside the queue there is a small register bank. It holds the fill colour, a clip window and a pixel-depth selector.

Software reads two values. The first is the number of free queue slots, which it checks before writing a whole command. The second is a status word, which it polls until it reads zero so that its own framebuffer accesses follow the drawing that was queued. Each pixel transfer uses one request on a framebuffer memory port. That port has a ready handshake.

A copy carries a two-bit walk direction in its opcode word. Software picks the direction from how the source and destination corners compare. The engine starts from the corner that direction names, so a pixel is never read after it has been overwritten.

Top module: `rect_engine`

## Requirements
- R1: The command queue holds up to FIFO_DEPTH words. `free_slots` equals FIFO_DEPTH minus the number of words stored and not yet taken by the command decoder. After reset it equals FIFO_DEPTH.
- R2: A fill command has three words: the word 0x09410000, then a destination word (y in bits 31:16, x in bits 15:0), then a size word (height in bits 31:16, width in bits 15:0). Pixels are written row by row from the top-left, left to right within a row.
- R3: The fill colour comes from the colour register (select 0). The value used is the one held when the command starts executing. No colour word appears in the queue.
- R4: A copy command starts with a word carrying 0x0D in bits 31:24, a direction code from 0x44 to 0x47 in bits 23:16, and zero in bits 15:0. It is followed by a source word, a destination word and a size word, each with y or height high and x or width low. For each pixel the source is read before the destination is written.
- R5: In the direction code, bit 0 set walks columns from right to left and bit 1 set walks rows from bottom to top. Software chooses the code as follows: 0x44 if src_x>=dst_x and src_y>=dst_y; otherwise 0x46 if src_x>=dst_x and src_y<=dst_y; otherwise 0x45 if src_x<=dst_x and src_y>=dst_y; otherwise 0x47. With that choice, an overlapping copy gives every destination pixel the source value from before the copy.
- R6: `status` has bits 0, 4, 5 and 8 (mask 0x131) for executing, queue not empty, command being assembled or waiting, and memory request active. All other bits read zero. The word reads zero when nothing is queued or executing, and it is nonzero in the cycle after an accepted queue write.
- R7: The clip registers are x-low (select 1), x-high (2), y-low (3) and y-high (4). After reset they hold 0, H_RES, 0 and V_RES. A destination pixel is drawn only if x-low<=x<x-high and y-low<=y<y-high. A pixel outside the window is skipped with no memory access, and for a copy that includes its read.
- R8: Bit 15 of the mode register (select 5) selects 16-bit pixels when 1 and 8-bit pixels when 0. After reset it is 1. In 16-bit mode the address is 2*(y*PITCH+x). In 8-bit mode it is y*PITCH+x and write data bits 15:8 are zero.
- R9: A command with zero width or zero height completes with no memory access, and the engine returns to idle.
- R10: A first word that is neither a fill opcode nor a valid copy opcode is dropped on its own. The engine stays idle and the next word is decoded as a new opcode.
- R11: A memory request keeps its address, direction and write data stable until `mem_ready` is high. Read data is taken in the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Queue write strobe |
| cmd_wr_data | input | 32 | Command word |
| free_slots | output | $clog2(FIFO_DEPTH+1) | Free queue slots |
| status | output | 16 | Busy status, zero when idle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wr_data | input | 16 | Register write data |
| mem_req | output | 1 | Framebuffer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Framebuffer address |
| mem_wdata | output | 16 | Pixel write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 16 | Pixel read data, valid with mem_ready on a read |

## Verification
The bench builds the engine with a 16 by 12 screen, a pitch of 16, a 4-word queue and 12 address bits. With those values the queue fills after one queued command, so the free-slot count and the busy bits can be seen stalled under a held memory port. Every clip edge and screen edge lies within a few pixels of the rectangles used, and all four copy directions fit as overlapping copies inside a 512-entry memory model. A scoreboard holds the expected write order and data, and the memory model answers reads with stalls inserted, so a wrong walk order shows up as wrong data.

// File: rtl/rect_pkg.sv
package rect_pkg;

    localparam logic [31:0] OPC_FILL     = 32'h0941_0000;
    localparam logic [7:0]  OPC_COPY_TOP = 8'h0D;

    localparam logic [2:0] SEL_COLOUR = 3'd0;
    localparam logic [2:0] SEL_XLO    = 3'd1;
    localparam logic [2:0] SEL_XHI    = 3'd2;
    localparam logic [2:0] SEL_YLO    = 3'd3;
    localparam logic [2:0] SEL_YHI    = 3'd4;
    localparam logic [2:0] SEL_MODE   = 3'd5;

    localparam int STB_RUN   = 0;
    localparam int STB_QUEUE = 4;
    localparam int STB_PARSE = 5;
    localparam int STB_MEM   = 8;

    typedef enum logic [1:0] {
        OP_FILL = 2'd0,
        OP_COPY = 2'd1
    } op_e;

    typedef struct packed {
        logic [15:0] y;
        logic [15:0] x;
    } point_t;

    typedef struct packed {
        op_e        op;
        logic [1:0] dir;
        point_t     src;
        point_t     dst;
        point_t     size;
    } cmd_t;

    typedef struct packed {
        logic [15:0] x_lo;
        logic [15:0] x_hi;
        logic [15:0] y_lo;
        logic [15:0] y_hi;
    } clip_t;

    function automatic logic is_copy_word(logic [31:0] w);
        return (w[31:24] == OPC_COPY_TOP) && (w[23:18] == 6'b010001) && (w[15:0] == 16'h0);
    endfunction

endpackage

// File: rtl/rect_cmd_fifo.sv
module rect_cmd_fifo #(
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [31:0]   din,
    input  logic          pop,
    output logic [31:0]   dout,
    output logic          not_empty,
    output logic [CW-1:0] free
);

    logic [31:0]   store [DEPTH];
    logic [PW-1:0] rd_p;
    logic [PW-1:0] wr_p;
    logic [CW-1:0] count;
    logic          full;
    logic          take_in;
    logic          give_out;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign take_in   = push && !full;
    assign give_out  = pop && not_empty;
    assign dout      = store[rd_p];
    assign free      = CW'(DEPTH) - count;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
        end else begin
            if (take_in) begin
                store[wr_p] <= din;
                wr_p        <= bump(wr_p);
            end
            if (give_out) begin
                rd_p <= bump(rd_p);
            end
            case ({take_in, give_out})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count))); // R1

endmodule

// File: rtl/rect_cmd_parser.sv
module rect_cmd_parser
    import rect_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        word_avail,
    input  logic [31:0] word_in,
    output logic        word_pop,
    output logic        cmd_valid,
    output cmd_t        cmd_out,
    input  logic        cmd_take,
    output logic        assembling
);

    logic [1:0] widx;
    cmd_t       acc;

    assign word_pop   = word_avail && !cmd_valid;
    assign assembling = (widx != 2'd0);
    assign cmd_out    = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            widx      <= 2'd0;
            cmd_valid <= 1'b0;
            acc       <= '0;
        end else begin
            if (cmd_take) begin
                cmd_valid <= 1'b0;
            end
            if (word_pop) begin
                unique case (widx)
                    2'd0: begin
                        if (word_in == OPC_FILL) begin
                            acc.op  <= OP_FILL;
                            acc.dir <= 2'b00;
                            acc.src <= '0;
                            widx    <= 2'd2;
                        end else if (is_copy_word(word_in)) begin
                            acc.op  <= OP_COPY;
                            acc.dir <= word_in[17:16];
                            widx    <= 2'd1;
                        end
                    end
                    2'd1: begin
                        acc.src <= point_t'(word_in);
                        widx    <= 2'd2;
                    end
                    2'd2: begin
                        acc.dst <= point_t'(word_in);
                        widx    <= 2'd3;
                    end
                    default: begin
                        acc.size  <= point_t'(word_in);
                        widx      <= 2'd0;
                        cmd_valid <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_DROP_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
        (word_pop && widx == 2'd0 && word_in != OPC_FILL && !is_copy_word(word_in))
        |=> (widx == 2'd0 && !cmd_valid)); // R10

endmodule

// File: rtl/rect_walker.sv
module rect_walker
    import rect_pkg::*;
#(
    parameter int PITCH = 640,
    parameter int AW    = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  cmd_t          cmd_in,
    output logic          cmd_take,
    input  clip_t         clip_in,
    input  logic [15:0]   colour_in,
    input  logic          wide_in,
    output logic          active,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [15:0]   mem_rdata
);

    localparam logic [AW-1:0] PITCH_A = AW'(PITCH);

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_PIX  = 2'd1,
        W_RD   = 2'd2,
        W_WR   = 2'd3
    } wstate_e;

    wstate_e     st;
    cmd_t        c;
    clip_t       l_clip;
    logic [15:0] l_col;
    logic        l_wide;
    logic [15:0] cx;
    logic [15:0] cy;
    logic [15:0] rd_buf;

    logic [15:0] col;
    logic [15:0] row;
    logic [16:0] dx17;
    logic [16:0] dy17;
    logic        in_win;
    logic        last_col;
    logic        last_row;
    logic [AW-1:0] src_a;
    logic [AW-1:0] dst_a;

    function automatic logic [AW-1:0] pix_addr(logic [15:0] x, logic [15:0] y, logic w16);
        logic [AW-1:0] idx;
        idx = AW'(y) * PITCH_A + AW'(x);
        return w16 ? (idx << 1) : idx;
    endfunction

    always_comb begin
        col      = c.dir[0] ? (c.size.x - 16'd1 - cx) : cx;
        row      = c.dir[1] ? (c.size.y - 16'd1 - cy) : cy;
        dx17     = {1'b0, c.dst.x} + {1'b0, col};
        dy17     = {1'b0, c.dst.y} + {1'b0, row};
        in_win   = (dx17 >= {1'b0, l_clip.x_lo}) && (dx17 < {1'b0, l_clip.x_hi}) &&
                   (dy17 >= {1'b0, l_clip.y_lo}) && (dy17 < {1'b0, l_clip.y_hi});
        last_col = (cx == c.size.x - 16'd1);
        last_row = (cy == c.size.y - 16'd1);
        src_a    = pix_addr(c.src.x + col, c.src.y + row, l_wide);
        dst_a    = pix_addr(dx17[15:0], dy17[15:0], l_wide);
    end

    assign cmd_take = (st == W_IDLE) && cmd_valid;
    assign active   = (st != W_IDLE);
    assign mem_req  = (st == W_RD) || (st == W_WR);
    assign mem_we   = (st == W_WR);
    assign mem_addr = (st == W_RD) ? src_a : dst_a;

    always_comb begin
        mem_wdata = (c.op == OP_COPY) ? rd_buf : l_col;
        if (!l_wide) begin
            mem_wdata[15:8] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            c      <= '0;
            l_clip <= '0;
            l_col  <= '0;
            l_wide <= 1'b0;
            cx     <= '0;
            cy     <= '0;
            rd_buf <= '0;
        end else begin
            unique case (st)
                W_IDLE: begin
                    if (cmd_valid) begin
                        c      <= cmd_in;
                        l_clip <= clip_in;
                        l_col  <= colour_in;
                        l_wide <= wide_in;
                        cx     <= '0;
                        cy     <= '0;
                        if (cmd_in.size.x != 16'd0 && cmd_in.size.y != 16'd0) begin
                            st <= W_PIX;
                        end
                    end
                end
                W_PIX: begin
                    if (in_win) begin
                        st <= (c.op == OP_COPY) ? W_RD : W_WR;
                    end else if (last_col) begin
                        cx <= '0;
                        cy <= cy + 16'd1;
                        if (last_row) st <= W_IDLE;
                    end else begin
                        cx <= cx + 16'd1;
                    end
                end
                W_RD: begin
                    if (mem_ready) begin
                        rd_buf <= mem_rdata;
                        st     <= W_WR;
                    end
                end
                default: begin
                    if (mem_ready) begin
                        if (last_col) begin
                            cx <= '0;
                            cy <= cy + 16'd1;
                            st <= last_row ? W_IDLE : W_PIX;
                        end else begin
                            cx <= cx + 16'd1;
                            st <= W_PIX;
                        end
                    end
                end
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

    AST_COPY_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && c.op == OP_COPY) |-> !mem_we); // R4

    AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (rst)
        (cmd_take && (cmd_in.size.x == 16'd0 || cmd_in.size.y == 16'd0)) |=> (!mem_req && !active)); // R9

endmodule

// File: rtl/rect_engine.sv
module rect_engine
    import rect_pkg::*;
#(
    parameter int H_RES      = 640,
    parameter int V_RES      = 480,
    parameter int PITCH      = H_RES,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 24
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cmd_wr_en,
    input  logic [31:0]                      cmd_wr_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  free_slots,
    output logic [15:0]                      status,
    input  logic                             reg_wr_en,
    input  logic [2:0]                       reg_sel,
    input  logic [15:0]                      reg_wr_data,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic [15:0]                      mem_wdata,
    input  logic                             mem_ready,
    input  logic [15:0]                      mem_rdata
);

    logic        q_not_empty;
    logic [31:0] q_word;
    logic        q_pop;
    logic        cmd_valid;
    cmd_t        cmd;
    logic        cmd_take;
    logic        assembling;
    logic        walk_active;

    clip_t       clip_r;
    logic [15:0] colour_r;
    logic        wide_r;
    logic        unused_mode_bits;

    assign unused_mode_bits = ^reg_wr_data[14:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_r    <= '0;
            clip_r.x_lo <= '0;
            clip_r.x_hi <= 16'(H_RES);
            clip_r.y_lo <= '0;
            clip_r.y_hi <= 16'(V_RES);
            wide_r      <= 1'b1;
        end else if (reg_wr_en) begin
            case (reg_sel)
                SEL_COLOUR: colour_r    <= reg_wr_data;
                SEL_XLO:    clip_r.x_lo <= reg_wr_data;
                SEL_XHI:    clip_r.x_hi <= reg_wr_data;
                SEL_YLO:    clip_r.y_lo <= reg_wr_data;
                SEL_YHI:    clip_r.y_hi <= reg_wr_data;
                SEL_MODE:   wide_r      <= reg_wr_data[15];
                default:    ;
            endcase
        end
    end

    rect_cmd_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_wr_en),
        .din       (cmd_wr_data),
        .pop       (q_pop),
        .dout      (q_word),
        .not_empty (q_not_empty),
        .free      (free_slots)
    );

    rect_cmd_parser i_parser (
        .clk        (clk),
        .rst        (rst),
        .word_avail (q_not_empty),
        .word_in    (q_word),
        .word_pop   (q_pop),
        .cmd_valid  (cmd_valid),
        .cmd_out    (cmd),
        .cmd_take   (cmd_take),
        .assembling (assembling)
    );

    rect_walker #(
        .PITCH (PITCH),
        .AW    (ADDR_W)
    ) i_walker (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd),
        .cmd_take  (cmd_take),
        .clip_in   (clip_r),
        .colour_in (colour_r),
        .wide_in   (wide_r),
        .active    (walk_active),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    always_comb begin
        status            = '0;
        status[STB_RUN]   = walk_active;
        status[STB_QUEUE] = q_not_empty;
        status[STB_PARSE] = assembling || cmd_valid;
        status[STB_MEM]   = mem_req;
    end

    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && free_slots != '0) |=> (status != 16'h0)); // R6

endmodule

// File: tb/test_rect_engine.sv
`timescale 1ns / 100ps
module test_rect_engine;
    import rect_pkg::*;

    localparam int HR = 16;
    localparam int VR = 12;
    localparam int PT = 16;
    localparam int FD = 4;
    localparam int AWB = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        cmd_wr_en = 1'b0;
    logic [31:0] cmd_wr_data = '0;
    logic [2:0]  free_slots;
    logic [15:0] status;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic        mem_req;
    logic        mem_we;
    logic [AWB-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata;

    logic [15:0] mem [0:511];
    assign mem_rdata = mem[mem_addr[8:0]];

    rect_engine #(
        .H_RES(HR), .V_RES(VR), .PITCH(PT), .FIFO_DEPTH(FD), .ADDR_W(AWB)
    ) i_rect_engine (
        .clk(clk), .rst(rst),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .free_slots(free_slots), .status(status),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wr_data(reg_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_err = 0;
    int rd_count = 0;
    int wr_count = 0;
    int cyc = 0;
    bit stall = 1'b0;
    bit finished = 1'b0;

    logic [27:0] exp_q [$];
    string       tag_q [$];

    int b_xlo = 0, b_xhi = HR, b_ylo = 0, b_yhi = VR;
    bit b_wide = 1'b1;
    logic [15:0] b_col = '0;

    task automatic check(input string tag, input bit ok, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: memory model plus scoreboard of writes
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            mem_ready = stall ? 1'b0 : ((cyc % 3) != 1);
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    logic [27:0] e;
                    string t;
                    wr_count++;
                    if (exp_q.size() == 0) begin
                        check("R2", 1'b0, "unexpected write", {mem_addr, mem_wdata}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, {mem_addr, mem_wdata} == e, "write addr/data",
                              {mem_addr, mem_wdata}, e);
                    end
                    mem[mem_addr[8:0]] = mem_wdata;
                end else begin
                    rd_count++;
                end
            end
        end
    end

    function automatic int pix_addr(input int x, input int y);
        return b_wide ? 2 * (y * PT + x) : (y * PT + x);
    endfunction

    function automatic bit in_clip(input int x, input int y);
        return (x >= b_xlo) && (x < b_xhi) && (y >= b_ylo) && (y < b_yhi);
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = w;
        @(negedge clk);
        cmd_wr_en   = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [15:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_sel     = sel;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        case (sel)
            SEL_COLOUR: b_col = v;
            SEL_XLO:    b_xlo = int'(v);
            SEL_XHI:    b_xhi = int'(v);
            SEL_YLO:    b_ylo = int'(v);
            SEL_YHI:    b_yhi = int'(v);
            SEL_MODE:   b_wide = v[15];
            default:    ;
        endcase
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        while (quiet < 3) begin
            @(negedge clk);
            if (status == 16'h0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic do_fill(input int x, input int y, input int w, input int h, input string tag);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                if (in_clip(x + c, y + r)) begin
                    logic [15:0] d;
                    d = b_wide ? b_col : {8'h00, b_col[7:0]};
                    exp_q.push_back({AWB'(pix_addr(x + c, y + r)), d});
                    tag_q.push_back(tag);
                end
            end
        end
        push(OPC_FILL);
        push({16'(y), 16'(x)});
        push({16'(h), 16'(w)});
    endtask

    task automatic do_copy(input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h, input string tag, output int n);
        logic [7:0] code;
        n = 0;
        if (sx >= dx && sy >= dy)      code = 8'h44;
        else if (sx >= dx && sy <= dy) code = 8'h46;
        else if (sx <= dx && sy >= dy) code = 8'h45;
        else                           code = 8'h47;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                int col;
                int row;
                col = code[0] ? (w - 1 - c) : c;
                row = code[1] ? (h - 1 - r) : r;
                if (in_clip(dx + col, dy + row)) begin
                    logic [15:0] v;
                    v = mem[9'(pix_addr(sx + col, sy + row))];
                    if (!b_wide) v[15:8] = 8'h00;
                    exp_q.push_back({AWB'(pix_addr(dx + col, dy + row)), v});
                    tag_q.push_back(tag);
                    n++;
                end
            end
        end
        push({8'h0D, code, 16'h0000});
        push({16'(sy), 16'(sx)});
        push({16'(dy), 16'(dx)});
        push({16'(h), 16'(w)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL R6 watchdog: actual busy expected idle");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        int r0;
        int w0;
        for (int i = 0; i < 512; i++) mem[i] = 16'(i * 37 + 5);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R1", free_slots == 3'(FD), "free slots after reset", free_slots, FD);
        check("R6", status == 16'h0, "status after reset", status, 0);
        check("R11", mem_req == 1'b0, "no request after reset", mem_req, 0);

        // R2 / R3: fills with two colours
        wreg(SEL_COLOUR, 16'hABCD);
        do_fill(2, 3, 4, 2, "R2");
        wait_idle();
        wreg(SEL_COLOUR, 16'h5A3C);
        do_fill(10, 0, 3, 3, "R3");
        wait_idle();
        // fill touching the bottom-right screen corner
        do_fill(14, 10, 2, 2, "R2");
        wait_idle();

        // R7: clipped fill and clipped copy
        wreg(SEL_XLO, 16'd1);
        wreg(SEL_XHI, 16'd5);
        wreg(SEL_YLO, 16'd2);
        wreg(SEL_YHI, 16'd4);
        wreg(SEL_COLOUR, 16'h1234);
        do_fill(0, 1, 7, 4, "R7");
        wait_idle();
        r0 = rd_count;
        do_copy(8, 6, 3, 1, 4, 4, "R7", n);
        wait_idle();
        check("R7", (rd_count - r0) == n, "reads of clipped copy", rd_count - r0, n);
        wreg(SEL_XLO, 16'd0);
        wreg(SEL_XHI, 16'(HR));
        wreg(SEL_YLO, 16'd0);
        wreg(SEL_YHI, 16'(VR));

        // R4: plain copy, R5: overlapping copies in all four directions
        do_copy(0, 8, 8, 9, 3, 2, "R4", n);
        wait_idle();
        do_copy(2, 2, 4, 3, 5, 3, "R5", n);
        wait_idle();
        do_copy(5, 6, 3, 4, 5, 4, "R5", n);
        wait_idle();
        do_copy(6, 3, 4, 4, 5, 4, "R5", n);
        wait_idle();
        do_copy(2, 6, 4, 5, 5, 4, "R5", n);
        wait_idle();

        // R8: 8-bit pixels
        wreg(SEL_MODE, 16'h0000);
        wreg(SEL_COLOUR, 16'hABCD);
        do_fill(1, 1, 3, 1, "R8");
        wait_idle();
        do_copy(0, 0, 2, 5, 3, 2, "R8", n);
        wait_idle();
        wreg(SEL_MODE, 16'h8000);

        // R9: zero width and zero height
        r0 = rd_count;
        w0 = wr_count;
        do_fill(3, 3, 0, 2, "R9");
        do_copy(1, 1, 4, 4, 3, 0, "R9", n);
        wait_idle();
        check("R9", (rd_count == r0) && (wr_count == w0), "accesses for empty rectangle",
              (rd_count - r0) + (wr_count - w0), 0);
        check("R9", status == 16'h0, "idle after empty rectangle", status, 0);

        // R10: unknown opcodes dropped one word at a time
        r0 = rd_count;
        w0 = wr_count;
        push(32'h1234_5678);
        push(32'h0D48_0000);
        wait_idle();
        check("R10", (rd_count == r0) && (wr_count == w0), "accesses after unknown word",
              (rd_count - r0) + (wr_count - w0), 0);
        check("R10", status == 16'h0, "idle after unknown word", status, 0);
        push(32'h0000_0001);
        wreg(SEL_COLOUR, 16'h7777);
        do_fill(6, 6, 2, 1, "R10");
        wait_idle();

        // R1 / R6 / R11: stalled memory port fills the queue
        stall = 1'b1;
        wreg(SEL_COLOUR, 16'h0F0F);
        do_fill(0, 0, 2, 1, "R11");
        do_fill(0, 1, 2, 1, "R11");
        do_fill(0, 2, 2, 1, "R11");
        repeat (6) @(negedge clk);
        check("R1", free_slots == 3'(FD - 3), "free slots while stalled", free_slots, FD - 3);
        check("R6", (status & 16'h0131) != 16'h0, "busy bits while stalled", status, 16'h0131);
        check("R6", (status & ~16'h0131) == 16'h0, "unused status bits", status & ~16'h0131, 0);
        check("R11", mem_req && mem_we, "request held while stalled", {mem_req, mem_we}, 2'b11);
        stall = 1'b0;
        wait_idle();
        check("R1", free_slots == 3'(FD), "free slots after drain", free_slots, FD);
        check("R6", status == 16'h0, "status after drain", status, 0);

        check("R2", exp_q.size() == 0, "expected writes left over", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule